// File: doc/BRIEF.md
# Two-Operand NaN Result Selector

This block produces the NaN result of a two-input floating-point operation when at least one input is a NaN. It accepts binary32 or binary64 operands on a shared 64-bit path. Each operand is sorted into one of three classes: ordinary value, quiet NaN or signaling NaN. The meaning of the top fraction bit is set at run time by a polarity input, and a separate control can turn signaling detection off altogether. A two-bit policy input then picks which operand is returned. If the picked operand is a signaling NaN, the block quiets it, and a default-NaN mode can replace the result entirely.

The result path is purely combinational. The only state is a sticky invalid-operation flag. It is set on any clock edge where a valid input pair contains a signaling NaN, and it stays set until a clear input is pulsed or reset is applied. An arithmetic unit places the block after its operand classification and uses its result whenever an operand is a NaN.

Top module: `nan_select`

## Requirements
- R1: With `invPol`=0, an operand is a NaN when its exponent field is all ones and its fraction is nonzero. A NaN whose fraction MSB (bit 51 for binary64, bit 22 for binary32) is 1 is quiet, and a NaN with that bit 0 is signaling.
- R2: With `invPol`=1, a NaN whose fraction MSB is 1 is signaling, and a NaN whose fraction MSB is 0 (so its lower fraction bits are nonzero) is quiet.
- R3: With `noSnan`=1, every NaN is treated as quiet. No operand is silenced and the invalid flag is never set.
- R4: `policy`=0 (ordered) returns the first match from this list: A if A is signaling, then B if B is signaling, then A if A is quiet, otherwise B.
- R5: `policy`=1 returns A when A is any NaN and B otherwise. `policy`=2 returns B when B is any NaN and A otherwise.
- R6: Under `policy`=3, a signaling NaN paired with a quiet NaN yields the quiet one. Two NaNs of the same class yield the one with the larger significand. A lone NaN is returned whatever the other operand holds.
- R7: For R6, significands are compared on the word with its sign bit removed. When the two are equal, the operand with the smaller raw word wins, so a positive sign beats a negative one.
- R8: When the returned operand is signaling, the block quiets it. With `invPol`=0 this means setting the fraction MSB and keeping the rest of the word. With `invPol`=1 the result is the default NaN.
- R9: The default NaN is 0x7FF8000000000000 for binary64 and 0x7FC00000 for binary32 when `invPol`=0. When `invPol`=1 it is 0x7FF7FFFFFFFFFFFF for binary64 and 0x7FBFFFFF for binary32.
- R10: With `dnMode`=1 the result is always the default NaN. A signaling input still sets the invalid flag.
- R11: `fmtDouble`=0 selects binary32 on bits 31:0. The upper input bits are ignored and result bits 63:32 are zero.
- R12: `invalidSticky` reads 0 after reset. It becomes 1 after a clock edge where `inValid`=1 and either operand is signaling, and this set takes priority over `clearInvalid`. Otherwise `clearInvalid`=1 clears it, and without a set or a clear it holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the sticky flag |
| rstN | input | 1 | Active-low asynchronous reset |
| inValid | input | 1 | Operand pair is live this cycle; required to set the flag |
| clearInvalid | input | 1 | Clears the sticky invalid flag |
| fmtDouble | input | 1 | 1 = binary64, 0 = binary32 on the low 32 bits |
| invPol | input | 1 | Inverts the meaning of the fraction MSB for NaN class |
| noSnan | input | 1 | Treat every NaN as quiet |
| dnMode | input | 1 | Force the default NaN as result |
| policy | input | 2 | 0 ordered, 1 first-NaN, 2 last-NaN, 3 larger-significand |
| opA | input | 64 | First operand |
| opB | input | 64 | Second operand |
| result | output | 64 | Selected, quieted or default NaN |
| invalidSticky | output | 1 | Sticky invalid-operation flag |

## Verification
The bench targets significand ties that differ only in sign. A design that compared raw words, or kept the sign bit in the comparison, would return the negative NaN in that case. It also runs signaling-with-quiet pairs under the larger-significand policy, which a plain magnitude compare would get wrong whenever the signaling NaN has the larger payload. Inverted polarity is exercised too: there, quieting by setting the MSB would leave a NaN that is still signaling instead of producing the default NaN. Binary32 operands are driven with random upper bits, which exposes any leakage into the result. Finally, the bench pulses clear and a signaling input in the same cycle to pin down which one takes priority for the flag.

// File: rtl/nan_sel_pkg.sv
package nan_sel_pkg;

  typedef enum logic [1:0] {
    PICK_ORDERED = 2'd0,
    PICK_FIRST   = 2'd1,
    PICK_LAST    = 2'd2,
    PICK_LARGER  = 2'd3
  } pickPolicy_e;

  // Operand information produced by the datapath for the control
  typedef struct packed {
    logic aNan;
    logic aSnan;
    logic bNan;
    logic bSnan;
    logic aLarger;
  } opClass_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic pickB;
    logic quietBit;
    logic useDefault;
    logic raise;
  } ctrlStrobe_t;

endpackage

// File: rtl/nan_classify.sv
module nan_classify #(
  parameter int DBL_EXP  = 11,
  parameter int DBL_FRAC = 52,
  parameter int SGL_EXP  = 8,
  parameter int SGL_FRAC = 23
) (
  input  logic [DBL_EXP+DBL_FRAC-1:0] mag,
  input  logic                        fmtDouble,
  input  logic                        invPol,
  input  logic                        noSnan,
  output logic                        isNan,
  output logic                        isSnan
);
  localparam int SGL_W = 1 + SGL_EXP + SGL_FRAC;

  logic [DBL_EXP-1:0]  dExp;
  logic [DBL_FRAC-1:0] dFrac;
  logic [SGL_EXP-1:0]  sExp;
  logic [SGL_FRAC-1:0] sFrac;
  logic expOnes, fracNz, topBit;

  always_comb begin
    dExp    = mag[DBL_EXP+DBL_FRAC-1 -: DBL_EXP];
    dFrac   = mag[DBL_FRAC-1:0];
    sExp    = mag[SGL_W-2 -: SGL_EXP];
    sFrac   = mag[SGL_FRAC-1:0];
    expOnes = fmtDouble ? (&dExp) : (&sExp);
    fracNz  = fmtDouble ? (|dFrac) : (|sFrac);
    topBit  = fmtDouble ? dFrac[DBL_FRAC-1] : sFrac[SGL_FRAC-1];
    isNan   = expOnes & fracNz;
    isSnan  = isNan & ~noSnan & (topBit == invPol);
  end
endmodule

// File: rtl/nan_datapath.sv
module nan_datapath
  import nan_sel_pkg::*;
#(
  parameter int DBL_EXP  = 11,
  parameter int DBL_FRAC = 52,
  parameter int SGL_EXP  = 8,
  parameter int SGL_FRAC = 23
) (
  input  logic [1+DBL_EXP+DBL_FRAC-1:0] opA,
  input  logic [1+DBL_EXP+DBL_FRAC-1:0] opB,
  input  logic                          fmtDouble,
  input  logic                          invPol,
  input  logic                          noSnan,
  input  ctrlStrobe_t                   strobe,
  output opClass_t                      cls,
  output logic [1+DBL_EXP+DBL_FRAC-1:0] result
);
  localparam int DBL_W = 1 + DBL_EXP + DBL_FRAC;
  localparam int SGL_W = 1 + SGL_EXP + SGL_FRAC;
  localparam int PAD_W = DBL_W - SGL_W;

  logic [DBL_W-1:0] opArr [2];
  logic [1:0]       nanV, snanV;

  assign opArr[0] = opA;
  assign opArr[1] = opB;

  for (genvar i = 0; i < 2; i++) begin : g_cls
    nan_classify #(
      .DBL_EXP(DBL_EXP), .DBL_FRAC(DBL_FRAC),
      .SGL_EXP(SGL_EXP), .SGL_FRAC(SGL_FRAC)
    ) u_cls (
      .mag      (opArr[i][DBL_W-2:0]),
      .fmtDouble(fmtDouble),
      .invPol   (invPol),
      .noSnan   (noSnan),
      .isNan    (nanV[i]),
      .isSnan   (snanV[i])
    );
  end

  logic [DBL_W-1:0] rawA, rawB, chosen, dnWord, quietMask;
  logic [DBL_W-2:0] magA, magB;

  always_comb begin
    rawA = fmtDouble ? opA : {{PAD_W{1'b0}}, opA[SGL_W-1:0]};
    rawB = fmtDouble ? opB : {{PAD_W{1'b0}}, opB[SGL_W-1:0]};
    magA = fmtDouble ? opA[DBL_W-2:0] : {{PAD_W{1'b0}}, opA[SGL_W-2:0]};
    magB = fmtDouble ? opB[DBL_W-2:0] : {{PAD_W{1'b0}}, opB[SGL_W-2:0]};

    cls.aNan    = nanV[0];
    cls.aSnan   = snanV[0];
    cls.bNan    = nanV[1];
    cls.bSnan   = snanV[1];
    cls.aLarger = (magA > magB) | ((magA == magB) & (rawA < rawB));

    if (fmtDouble)
      dnWord = {1'b0, {DBL_EXP{1'b1}}, ~invPol, {(DBL_FRAC-1){invPol}}};
    else
      dnWord = {{PAD_W{1'b0}}, 1'b0, {SGL_EXP{1'b1}}, ~invPol, {(SGL_FRAC-1){invPol}}};

    quietMask = '0;
    if (fmtDouble) quietMask[DBL_FRAC-1] = 1'b1;
    else           quietMask[SGL_FRAC-1] = 1'b1;

    chosen = strobe.pickB ? rawB : rawA;
    if (strobe.useDefault)    result = dnWord;
    else if (strobe.quietBit) result = chosen | quietMask;
    else                      result = chosen;
  end
endmodule

// File: rtl/nan_control.sv
module nan_control
  import nan_sel_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic        clearInvalid,
  input  logic [1:0]  policy,
  input  logic        dnMode,
  input  logic        invPol,
  input  opClass_t    cls,
  output ctrlStrobe_t strobe,
  output logic        invalidSticky
);
  logic pickB, chosenSnan;

  always_comb begin
    case (pickPolicy_e'(policy))
      PICK_ORDERED: pickB = cls.aSnan ? 1'b0 : cls.bSnan ? 1'b1 : cls.aNan ? 1'b0 : 1'b1;
      PICK_FIRST:   pickB = ~cls.aNan;
      PICK_LAST:    pickB = cls.bNan;
      default: begin
        if (cls.aSnan)
          pickB = cls.bSnan ? ~cls.aLarger : cls.bNan;
        else if (cls.aNan)
          pickB = (cls.bNan & ~cls.bSnan) ? ~cls.aLarger : 1'b0;
        else
          pickB = 1'b1;
      end
    endcase
    chosenSnan        = pickB ? cls.bSnan : cls.aSnan;
    strobe.pickB      = pickB;
    strobe.raise      = cls.aSnan | cls.bSnan;
    strobe.useDefault = dnMode | (chosenSnan & invPol);
    strobe.quietBit   = chosenSnan & ~invPol;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                       invalidSticky <= 1'b0;
    else if (inValid && strobe.raise) invalidSticky <= 1'b1;
    else if (clearInvalid)           invalidSticky <= 1'b0;
  end
endmodule

// File: rtl/nan_select.sv
module nan_select
  import nan_sel_pkg::*;
#(
  parameter int DBL_EXP  = 11,
  parameter int DBL_FRAC = 52,
  parameter int SGL_EXP  = 8,
  parameter int SGL_FRAC = 23
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          inValid,
  input  logic                          clearInvalid,
  input  logic                          fmtDouble,
  input  logic                          invPol,
  input  logic                          noSnan,
  input  logic                          dnMode,
  input  logic [1:0]                    policy,
  input  logic [1+DBL_EXP+DBL_FRAC-1:0] opA,
  input  logic [1+DBL_EXP+DBL_FRAC-1:0] opB,
  output logic [1+DBL_EXP+DBL_FRAC-1:0] result,
  output logic                          invalidSticky
);
  opClass_t    cls;
  ctrlStrobe_t strobe;

  nan_datapath #(
    .DBL_EXP(DBL_EXP), .DBL_FRAC(DBL_FRAC),
    .SGL_EXP(SGL_EXP), .SGL_FRAC(SGL_FRAC)
  ) u_dp (
    .opA      (opA),
    .opB      (opB),
    .fmtDouble(fmtDouble),
    .invPol   (invPol),
    .noSnan   (noSnan),
    .strobe   (strobe),
    .cls      (cls),
    .result   (result)
  );

  nan_control u_ctl (
    .clk          (clk),
    .rstN         (rstN),
    .inValid      (inValid),
    .clearInvalid (clearInvalid),
    .policy       (policy),
    .dnMode       (dnMode),
    .invPol       (invPol),
    .cls          (cls),
    .strobe       (strobe),
    .invalidSticky(invalidSticky)
  );
endmodule

// File: rtl/nan_select_chk.sv
module nan_select_chk #(
  parameter int DBL_EXP  = 11,
  parameter int DBL_FRAC = 52,
  parameter int SGL_EXP  = 8,
  parameter int SGL_FRAC = 23
) (
  input logic                          clk,
  input logic                          rstN,
  input logic                          inValid,
  input logic                          clearInvalid,
  input logic                          fmtDouble,
  input logic                          invPol,
  input logic                          noSnan,
  input logic                          dnMode,
  input logic                          anyNan,
  input logic                          raiseNow,
  input logic [1+DBL_EXP+DBL_FRAC-1:0] result,
  input logic                          invalidSticky
);
  localparam int DBL_W = 1 + DBL_EXP + DBL_FRAC;
  localparam int SGL_W = 1 + SGL_EXP + SGL_FRAC;

  logic [DBL_W-1:0] dnExp;
  always_comb begin
    dnExp = '0;
    if (fmtDouble) begin
      dnExp[DBL_W-2 -: DBL_EXP] = '1;
      dnExp[DBL_FRAC-1]         = ~invPol;
      if (invPol) dnExp[DBL_FRAC-2:0] = '1;
    end else begin
      dnExp[SGL_W-2 -: SGL_EXP] = '1;
      dnExp[SGL_FRAC-1]         = ~invPol;
      if (invPol) dnExp[SGL_FRAC-2:0] = '1;
    end
  end

  assert_sticky_set_R12: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && raiseNow) |=> invalidSticky);

  assert_sticky_hold_R12: assert property (@(posedge clk) disable iff (!rstN)
    (invalidSticky && !clearInvalid) |=> invalidSticky);

  assert_sticky_clear_R12: assert property (@(posedge clk) disable iff (!rstN)
    (clearInvalid && !(inValid && raiseNow)) |=> !invalidSticky);

  assert_no_raise_R3: assert property (@(posedge clk) disable iff (!rstN)
    noSnan |-> !raiseNow);

  assert_upper_zero_R11: assert property (@(posedge clk) disable iff (!rstN)
    !fmtDouble |-> (result[DBL_W-1:SGL_W] == '0));

  assert_default_nan_R10: assert property (@(posedge clk) disable iff (!rstN)
    dnMode |-> (result == dnExp));

  assert_quiet_out_R8: assert property (@(posedge clk) disable iff (!rstN)
    (fmtDouble && !invPol && !noSnan && anyNan) |-> result[DBL_FRAC-1]);
endmodule

bind nan_select nan_select_chk #(
  .DBL_EXP(DBL_EXP), .DBL_FRAC(DBL_FRAC),
  .SGL_EXP(SGL_EXP), .SGL_FRAC(SGL_FRAC)
) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .inValid      (inValid),
  .clearInvalid (clearInvalid),
  .fmtDouble    (fmtDouble),
  .invPol       (invPol),
  .noSnan       (noSnan),
  .dnMode       (dnMode),
  .anyNan       (cls.aNan | cls.bNan),
  .raiseNow     (strobe.raise),
  .result       (result),
  .invalidSticky(invalidSticky)
);

// File: tb/tb_nan_select.sv
module tb_nan_select;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rstN, inValid, clearInvalid, fmtDouble, invPol, noSnan, dnMode;
  logic [1:0]  policy;
  logic [63:0] opA, opB, result;
  logic        invalidSticky;
  logic        expSticky;
  int nChecks = 0;
  int nFail   = 0;

  nan_select dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .clearInvalid(clearInvalid),
    .fmtDouble(fmtDouble), .invPol(invPol), .noSnan(noSnan), .dnMode(dnMode),
    .policy(policy), .opA(opA), .opB(opB), .result(result),
    .invalidSticky(invalidSticky)
  );

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic void classify(logic [63:0] w, logic dbl, logic inv, logic nos,
                                   output logic isN, output logic isS);
    logic ones, nz, msb;
    ones = dbl ? (w[62:52] == 11'h7FF) : (w[30:23] == 8'hFF);
    nz   = dbl ? (w[51:0] != 0) : (w[22:0] != 0);
    msb  = dbl ? w[51] : w[22];
    isN  = ones && nz;
    isS  = isN && !nos && (inv ? msb : !msb);
  endfunction

  function automatic logic [63:0] defNan(logic dbl, logic inv);
    if (dbl) return inv ? 64'h7FF7FFFFFFFFFFFF : 64'h7FF8000000000000;
    return inv ? 64'h000000007FBFFFFF : 64'h000000007FC00000;
  endfunction

  function automatic logic [63:0] model(logic [63:0] a, logic [63:0] b, logic dbl,
      logic inv, logic nos, logic dn, logic [1:0] pol, output logic raise);
    logic an, as, bn, bs, aBig, pickB, cs;
    logic [63:0] ra, rb, ma, mb, ch;
    ra = dbl ? a : {32'b0, a[31:0]};
    rb = dbl ? b : {32'b0, b[31:0]};
    classify(ra, dbl, inv, nos, an, as);
    classify(rb, dbl, inv, nos, bn, bs);
    raise = as || bs;
    ma = dbl ? {ra[62:0], 1'b0} : {32'b0, ra[30:0], 1'b0};
    mb = dbl ? {rb[62:0], 1'b0} : {32'b0, rb[30:0], 1'b0};
    aBig = (ma > mb) || (ma == mb && ra < rb);
    case (pol)
      2'd0: pickB = as ? 1'b0 : bs ? 1'b1 : an ? 1'b0 : 1'b1;
      2'd1: pickB = !an;
      2'd2: pickB = bn;
      default: begin
        if (as && bs)                        pickB = !aBig;
        else if (an && bn && !as && !bs)     pickB = !aBig;
        else if (as && bn)                   pickB = 1'b1;
        else if (an && bs)                   pickB = 1'b0;
        else                                 pickB = !an;
      end
    endcase
    cs = pickB ? bs : as;
    ch = pickB ? rb : ra;
    if (dn) return defNan(dbl, inv);
    if (cs) return inv ? defNan(dbl, inv) : (ch | (dbl ? 64'h0008000000000000 : 64'h0000000000400000));
    return ch;
  endfunction

  // kind: 0 ordinary, 1 NaN msb set, 2 NaN msb clear, 3 infinity, 4 zero
  function automatic logic [63:0] mkOp(logic dbl, int kind);
    logic [63:0] w;
    w = {$urandom, $urandom};
    if (dbl) begin
      case (kind)
        1: w[62:51] = 12'hFFF;
        2: begin w[62:51] = 12'hFFE; if (w[50:0] == 0) w[0] = 1'b1; end
        3: w[62:0] = {11'h7FF, 52'h0};
        4: w[62:0] = '0;
        default: if (w[62:52] == 11'h7FF) w[62] = 1'b0;
      endcase
    end else begin
      case (kind)
        1: w[30:22] = 9'h1FF;
        2: begin w[30:22] = 9'h1FE; if (w[21:0] == 0) w[0] = 1'b1; end
        3: w[30:0] = {8'hFF, 23'h0};
        4: w[30:0] = '0;
        default: if (w[30:23] == 8'hFF) w[30] = 1'b0;
      endcase
    end
    return w;
  endfunction

  task automatic apply(logic [63:0] a, logic [63:0] b, logic dbl, logic inv, logic nos,
      logic dn, logic [1:0] pol, logic v, logic clr, logic [63:0] expR, string tag);
    logic rz;
    logic [63:0] dummy;
    @(negedge clk);
    opA = a; opB = b; fmtDouble = dbl; invPol = inv; noSnan = nos; dnMode = dn;
    policy = pol; inValid = v; clearInvalid = clr;
    dummy = model(a, b, dbl, inv, nos, dn, pol, rz);
    #1;
    check(tag, result, expR);
    if (v && rz) expSticky = 1'b1;
    else if (clr) expSticky = 1'b0;
    @(posedge clk);
    #1;
    check({tag, " sticky R12"}, {63'b0, invalidSticky}, {63'b0, expSticky});
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog R12: run hung, actual running expected done");
    summary();
    $finish;
  end

  initial begin
    logic rz;
    void'($urandom(32'h5EED));
    rstN = 1'b0; inValid = 0; clearInvalid = 0; fmtDouble = 1; invPol = 0;
    noSnan = 0; dnMode = 0; policy = 0; opA = '0; opB = '0; expSticky = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check("reset R12", {63'b0, invalidSticky}, 64'd0);
    @(negedge clk);
    rstN = 1'b1;

    // R1/R4/R8: signaling A silenced by setting fraction MSB
    apply(64'h7FF0000000000001, 64'h7FF8000000000005, 1, 0, 0, 0, 2'd0, 1, 0,
          64'h7FF8000000000001, "R1 R4 R8 ordered snan A");
    // R12: clear when no new event
    apply(64'h7FF8000000000005, 64'h3FF0000000000000, 1, 0, 0, 0, 2'd0, 1, 1,
          64'h7FF8000000000005, "R12 clear");
    // R12: signaling without inValid does not set
    apply(64'h7FF0000000000001, 64'h0, 1, 0, 0, 0, 2'd0, 0, 0,
          64'h7FF8000000000001, "R12 no valid");
    // R12: set wins over clear
    apply(64'h0, 64'h7FF0000000000002, 1, 0, 0, 0, 2'd0, 1, 1,
          64'h7FF8000000000002, "R12 set over clear");
    // R2/R8/R9: inverted polarity, signaling A replaced by default NaN
    apply(64'h7FF8000000000001, 64'h7FF4000000000000, 1, 1, 0, 0, 2'd0, 1, 1,
          64'h7FF7FFFFFFFFFFFF, "R2 R8 R9 inverted");
    // R3: no signaling NaNs, returned unchanged, no flag
    apply(64'h7FF0000000000001, 64'h3FF0000000000000, 1, 0, 1, 0, 2'd0, 1, 1,
          64'h7FF0000000000001, "R3 no snan");
    // R7: significand tie, positive wins
    apply(64'hFFF8000000000001, 64'h7FF8000000000001, 1, 0, 0, 0, 2'd3, 1, 0,
          64'h7FF8000000000001, "R7 tie B");
    apply(64'h7FF8000000000001, 64'hFFF8000000000001, 1, 0, 0, 0, 2'd3, 1, 0,
          64'h7FF8000000000001, "R7 tie A");
    // R6: signaling with quiet yields quiet
    apply(64'h7FF0000000000009, 64'hFFF8000000000000, 1, 0, 0, 0, 2'd3, 1, 0,
          64'hFFF8000000000000, "R6 snan vs qnan");
    // R5: first and last
    apply(64'h7FF8000000000003, 64'h7FF8000000000004, 1, 0, 0, 0, 2'd1, 1, 0,
          64'h7FF8000000000003, "R5 first");
    apply(64'h7FF8000000000003, 64'h7FF8000000000004, 1, 0, 0, 0, 2'd2, 1, 0,
          64'h7FF8000000000004, "R5 last");
    // R10/R9: default NaN mode, binary64 and binary32, flag still raised
    apply(64'h7FF0000000000001, 64'h0, 1, 0, 0, 1, 2'd0, 1, 1,
          64'h7FF8000000000000, "R10 R9 dn double");
    apply(64'h0, 64'h000000007F800001, 0, 1, 0, 1, 2'd0, 1, 1,
          64'h000000007FBFFFFF, "R10 R9 dn single inv");
    // R11: binary32 ignores upper bits
    apply(64'hDEADBEEF7FC00001, 64'h123456783F800000, 0, 0, 0, 0, 2'd0, 1, 1,
          64'h000000007FC00001, "R11 single");
    apply(64'hFFFFFFFF7F800001, 64'h0, 0, 0, 0, 0, 2'd0, 1, 0,
          64'h000000007FC00001, "R11 R8 single silence");

    for (int n = 0; n < 3000; n++) begin
      logic dbl, inv, nos, dn, v, clr;
      logic [1:0] pol;
      int kA, kB;
      logic [63:0] a, b, e;
      string tag;
      dbl = $urandom_range(0, 1);
      inv = ($urandom_range(0, 2) == 0);
      nos = ($urandom_range(0, 7) == 0);
      dn  = ($urandom_range(0, 7) == 0);
      v   = ($urandom_range(0, 7) != 0);
      clr = ($urandom_range(0, 7) == 0);
      pol = 2'($urandom_range(0, 3));
      kA = $urandom_range(0, 4);
      kB = $urandom_range(0, 4);
      if (kA != 1 && kA != 2 && kB != 1 && kB != 2) kA = 1 + $urandom_range(0, 1);
      a = mkOp(dbl, kA);
      b = mkOp(dbl, kB);
      if ($urandom_range(0, 7) == 0) begin
        b = a;
        if (dbl) b[63] = ~a[63]; else b[31] = ~a[31];
      end
      case (pol)
        2'd0: tag = "R4 random";
        2'd1: tag = "R5 random first";
        2'd2: tag = "R5 random last";
        default: tag = "R6 R7 random";
      endcase
      e = model(a, b, dbl, inv, nos, dn, pol, rz);
      apply(a, b, dbl, inv, nos, dn, pol, v, clr, e, tag);
    end

    summary();
    $finish;
  end
endmodule